// File: doc/BRIEF.md
# Radix-4 Booth Multiple Selector with Deferred Negation

This block forms the partial products of a radix-4 Booth multiplier without a carry chain. It takes an N-bit two's-complement multiplicand and an N-bit two's-complement multiplier. It splits the multiplier into N/2 overlapping three-bit groups. For each group it picks one multiple of the multiplicand from the set {-2y, -y, 0, +y, +2y}. The multiple comes out as an (N+2)-bit word together with a one-bit correction. Negative multiples are not incremented. The word holds the bitwise inverse of the positive multiple, and the correction bit, of unit weight, supplies the missing one.

The downstream accumulation tree adds each correction bit at the least significant position of its group's word. The block has no state. Both outputs are a pure function of the two operands, and no adder, incrementer or carry path appears anywhere in it.

Top module: `booth_ones_sel`

## Requirements
- R1: Group i decodes the multiplier bits (2i+1, 2i, 2i-1), most significant first. Group 0 uses a constant 0 in place of bit -1.
- R2: Codes 001 and 010 give the multiplicand sign-extended to N+2 bits, with correction bit 0.
- R3: Code 011 gives twice the sign-extended multiplicand (shifted left by one), with correction bit 0.
- R4: Code 100 gives the bitwise inverse of twice the sign-extended multiplicand, with correction bit 1.
- R5: Codes 101 and 110 give the bitwise inverse of the sign-extended multiplicand, with correction bit 1.
- R6: Codes 000 and 111 give an all-zero word with correction bit 0.
- R7: In every group word, the two most significant bits are equal, so no selected multiple overflows N+2 bits.
- R8: Take each word as signed, add its correction bit, and weight the result by 4^i. The sum over all groups equals the signed product x*y.
- R9: A group's correction bit is 1 exactly when its top code bit is 1 and its code is not 111.
- R10: Group i occupies word bits [i*(N+2) +: N+2] and correction bit i.
- R11: The outputs are combinational and reflect the current operands within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | N | Multiplicand y, two's complement |
| mplier_i | input | N | Multiplier x, two's complement |
| pp_word_o | output | (N/2)*(N+2) | Packed group words, group 0 in the low bits |
| pp_corr_o | output | N/2 | Per-group correction bit of unit weight |

## Verification
Every result depends on the current operands alone, so each is due in the same cycle the operands change, with zero register latency. The bench applies operands on the falling clock edge and samples one nanosecond later, well before the next rising edge. The sweep covers all operand pairs at N=8. Each group's word and correction bit are compared against a multiple computed arithmetically from the decoded code. The weighted sum of all groups is compared against the signed product.

// File: rtl/booth_sel_pkg.sv
package booth_sel_pkg;
  typedef struct packed {
    logic neg;  // invert the multiple, raise the correction bit
    logic dbl;  // select the doubled multiple
    logic nil;  // select zero
  } bsel_t;
endpackage

// File: rtl/booth_code_dec.sv
module booth_code_dec
  import booth_sel_pkg::*;
(
  input  logic [2:0] code_i,
  output bsel_t      sel_o
);
  always_comb begin
    sel_o = '{neg: 1'b0, dbl: 1'b0, nil: 1'b0};
    unique case (code_i)
      3'b000, 3'b111: sel_o.nil = 1'b1;
      3'b001, 3'b010: ;
      3'b011:         sel_o.dbl = 1'b1;
      3'b100:         begin sel_o.neg = 1'b1; sel_o.dbl = 1'b1; end
      default:        sel_o.neg = 1'b1;
    endcase
  end

  always_comb begin
    // R6
    nil_excl_chk: assert (!(sel_o.nil && (sel_o.neg || sel_o.dbl)))
      else $error("zero selection combined with another control");
  end
endmodule

// File: rtl/booth_mult_sel.sv
module booth_mult_sel
  import booth_sel_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] y_i,
  input  bsel_t        sel_i,
  output logic [N+1:0] word_o,
  output logic         corr_o
);
  localparam int W = N + 2;

  logic [W-1:0] ysx;
  logic [W-1:0] mag;

  always_comb begin
    ysx = {{2{y_i[N-1]}}, y_i};
    if (sel_i.nil)      mag = '0;
    else if (sel_i.dbl) mag = {ysx[W-2:0], 1'b0};
    else                mag = ysx;
    word_o = sel_i.neg ? ~mag : mag;
    corr_o = sel_i.neg;
  end

  always_comb begin
    // R7
    sign_ext_chk: assert (word_o[W-1] == word_o[W-2])
      else $error("multiple overflows group word");
    // R3
    dbl_lsb_chk: assert (!sel_i.dbl || (word_o[0] == corr_o))
      else $error("doubled multiple low bit wrong");
  end
endmodule

// File: rtl/booth_ones_sel.sv
module booth_ones_sel
  import booth_sel_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]               mcand_i,
  input  logic [N-1:0]               mplier_i,
  output logic [(N/2)*(N+2)-1:0]     pp_word_o,
  output logic [N/2-1:0]             pp_corr_o
);
  localparam int G = N / 2;
  localparam int W = N + 2;

  logic [N:0] xext;
  assign xext = {mplier_i, 1'b0};

  for (genvar gi = 0; gi < G; gi++) begin : g_grp
    logic [2:0]   code;
    bsel_t        sel;
    logic [W-1:0] word;
    logic         corr;

    assign code = xext[2*gi+2 -: 3];

    booth_code_dec u_dec (
      .code_i (code),
      .sel_o  (sel)
    );

    booth_mult_sel #(.N(N)) u_sel (
      .y_i    (mcand_i),
      .sel_i  (sel),
      .word_o (word),
      .corr_o (corr)
    );

    assign pp_word_o[gi*W +: W] = word;
    assign pp_corr_o[gi]        = corr;

    always_comb begin
      // R9
      corr_code_chk: assert (pp_corr_o[gi] == (code[2] && (code != 3'b111)))
        else $error("correction bit does not follow group code");
      // R6
      zero_word_chk: assert (!((code == 3'b000) || (code == 3'b111)) ||
                             (pp_word_o[gi*W +: W] == '0))
        else $error("zero code produced nonzero word");
    end
  end
endmodule

// File: tb/test_booth_ones_sel.sv
`timescale 1ns/1ps
module test_booth_ones_sel;
  localparam int N = 8;
  localparam int G = N / 2;
  localparam int W = N + 2;

  logic clk;
  logic rst_n;
  logic [N-1:0]   x, y;
  logic [G*W-1:0] pp;
  logic [G-1:0]   corr;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  booth_ones_sel #(.N(N)) i_booth_ones_sel (
    .mcand_i   (y),
    .mplier_i  (x),
    .pp_word_o (pp),
    .pp_corr_o (corr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check_vec();
    longint acc = 0;
    longint prod;
    for (int i = 0; i < G; i++) begin
      logic [2:0]   c;
      int           k;
      longint       mag;
      logic [63:0]  mbits;
      logic [W-1:0] wexp;
      logic         cexp;
      logic [W-1:0] wact;
      string        tag;
      // R1: group bits (2i+1, 2i, 2i-1), zero below bit 0
      c = {x[2*i+1], x[2*i], (i == 0) ? 1'b0 : x[2*i-1]};
      case (c)
        3'b001, 3'b010: begin k =  1; tag = "R1 R2 R10"; end
        3'b011:         begin k =  2; tag = "R1 R3 R10"; end
        3'b100:         begin k = -2; tag = "R1 R4 R10"; end
        3'b101, 3'b110: begin k = -1; tag = "R1 R5 R10"; end
        default:        begin k =  0; tag = "R1 R6 R10"; end
      endcase
      mag   = longint'((k < 0) ? -k : k) * longint'($signed(y));
      mbits = mag;
      wexp  = (k < 0) ? ~mbits[W-1:0] : mbits[W-1:0];
      cexp  = (k < 0);
      wact  = pp[i*W +: W];
      checks++;
      if (wact !== wexp) begin
        fails++;
        $display("FAIL %s x=%0d y=%0d group %0d word act=%b exp=%b", tag,
                 $signed(x), $signed(y), i, wact, wexp);
      end
      checks++;
      if (corr[i] !== cexp) begin
        fails++;
        $display("FAIL R9 x=%0d y=%0d group %0d corr act=%b exp=%b",
                 $signed(x), $signed(y), i, corr[i], cexp);
      end
      // R7: top two bits agree
      checks++;
      if (wact[W-1] !== wact[W-2]) begin
        fails++;
        $display("FAIL R7 group %0d top bits act=%b%b exp equal", i,
                 wact[W-1], wact[W-2]);
      end
      acc += (longint'($signed(wact)) + longint'(corr[i])) * (longint'(1) << (2*i));
    end
    prod = longint'($signed(x)) * longint'($signed(y));
    checks++;
    if (acc !== prod) begin
      fails++;
      $display("FAIL R8 x=%0d y=%0d sum act=%0d exp=%0d",
               $signed(x), $signed(y), acc, prod);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    x = '0;
    y = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R6: zero operands give all-zero words and no correction
    checks++;
    if (pp !== '0 || corr !== '0) begin
      fails++;
      $display("FAIL R6 idle act=%h/%b exp=0/0", pp, corr);
    end
    // R11: exhaustive sweep, outputs sampled in the same cycle
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        @(negedge clk);
        x = a[N-1:0];
        y = b[N-1:0];
        #1;
        check_vec();
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule